// File: doc/BRIEF.md
# Registered sum-of-products logic array

This block evaluates a set of sum-of-products functions whose structure is held entirely in a loadable configuration matrix. Each product term has an input-side row and an output-side row. The input-side row states, for each input variable, whether the variable enters the term true, enters it complemented, or is left out. The output-side row states which output OR gates the term drives. A single term may drive several outputs, so one set of terms can be shared across functions. The number of terms fixes the size of the array.

Evaluation is framed by two registers on a single clock, and two strobes pace it. On a `phase1_en` cycle the input register samples `in_vec`. On a `phase2_en` cycle the output register samples the array result that is computed from the registered inputs. The two strobes are never high in the same cycle.

Software writes one term row per cycle through `cfg_we`, `cfg_row` and `cfg_data`. Writes go into a staging copy of the matrix. The evaluating copy is refreshed from the staging copy at every `phase1_en` capture. As a result, a write first affects the evaluation that follows the next input capture.

Top module: `pla_eval`

## Requirements
- R1: A synchronous reset clears the input register and the output register. It also sets every term's input side to don't-care and every term's output side to unconnected. From the first clock edge after reset, and for any inputs and captures that follow without a write, `out_vec` reads all zero.
- R2: In `cfg_data`, bits [2i+1:2i] hold the code for input variable i. Code 00 leaves the variable out of the term, 01 requires it to be 0, and 10 requires it to be 1. Code 11 is reserved and forces the term to 0 regardless of the inputs.
- R3: In `cfg_data`, bit 2*N_IN+j connects the term to output j. Output j is the OR of every connected term, and one term may feed several outputs.
- R4: A term whose input-side codes are all 00 evaluates to 1 for every input value.
- R5: An output with no connected term reads 0 for every input value.
- R6: `in_vec` is sampled into the input register only on a `phase1_en` cycle. `out_vec` changes only on the clock edge of a `phase2_en` cycle. Both registers hold their value otherwise, and the two strobes are never high together.
- R7: After a `phase2_en` cycle, `out_vec` equals the function of the most recently captured inputs under the evaluating matrix. The new value appears at the clock edge that ends the strobe cycle.
- R8: A configuration write reaches the evaluating matrix at the first `phase1_en` capture in a cycle later than the write. A write issued in the same cycle as a capture waits for the following capture.
- R9: A write whose `cfg_row` is N_TERM or greater changes no term.
- R10: Use 3 inputs with a as bit 2, b as bit 1 and c as bit 0, 6 terms and 5 outputs. A program in which a, b'c', ac', a'b, b'c and b are each stored once produces the following for all 8 input values: f0 = a + b'c', f1 = ac' + a'b, f2 = b'c' + a'b, f3 = b'c + a and f4 = a + b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase1_en | input | 1 | Input capture strobe; also refreshes the evaluating matrix |
| phase2_en | input | 1 | Output capture strobe |
| in_vec | input | N_IN (3) | Input variables |
| cfg_we | input | 1 | Configuration write enable |
| cfg_row | input | clog2(N_TERM) (3) | Term row to write |
| cfg_data | input | 2*N_IN+N_OUT (11) | {output-side bits, input-side codes} for the row |
| out_vec | output | N_OUT (5) | Registered function outputs |

## Verification
A corrupted staging or evaluating row appears at the ports only through an output that the row drives. It shows only for input values at which the faulty literal decides the term, and only at the first output capture after the corrupted copy is used. For this reason the shared-term program is swept over all eight input values. A wrong register enable, or a matrix refresh one capture early or late, leaves `out_vec` one evaluation stale. The bench detects this at the cycle after the relevant `phase2_en` strobe by evaluating immediately around configuration writes.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_SKIP = 2'b00,
    LIT_NEG  = 2'b01,
    LIT_POS  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // One literal position of an AND-plane line: does it let the line stay high?
  function automatic logic lit_pass(input logic [1:0] code, input logic v);
    case (lit_code_e'(code))
      LIT_SKIP: lit_pass = 1'b1;
      LIT_NEG:  lit_pass = ~v;
      LIT_POS:  lit_pass = v;
      default:  lit_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 5,
  localparam int CFG_W = 2 * N_IN + N_OUT,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [ROW_W-1:0]                   cfg_row,
  input  logic [CFG_W-1:0]                   cfg_data,
  input  logic                               load_active,
  output logic [N_TERM-1:0][CFG_W-1:0]       stage_rows,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_cfg,
  output logic [N_TERM-1:0][N_OUT-1:0]       or_cfg
);

  logic [N_TERM-1:0][CFG_W-1:0] active_rows;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic row_hit;
    assign row_hit = cfg_we && (cfg_row == ROW_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_rows[t] <= '0;
      end else if (row_hit) begin
        stage_rows[t] <= cfg_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active_rows[t] <= '0;
      end else if (load_active) begin
        active_rows[t] <= stage_rows[t];
      end
    end

    assign and_cfg[t] = active_rows[t][2*N_IN-1:0];
    assign or_cfg[t]  = active_rows[t][CFG_W-1:2*N_IN];
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 6
) (
  input  logic [N_IN-1:0]                  in_q,
  input  logic [N_TERM-1:0][2*N_IN-1:0]    and_cfg,
  output logic [N_TERM-1:0]                term_hit
);
  import pla_pkg::*;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_comb begin
      term_hit[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        term_hit[t] = term_hit[t] & lit_pass(and_cfg[t][2*i +: 2], in_q[i]);
      end
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 5
) (
  input  logic [N_TERM-1:0]                term_hit,
  input  logic [N_TERM-1:0][N_OUT-1:0]     or_cfg,
  output logic [N_OUT-1:0]                 or_res
);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    always_comb begin
      or_res[j] = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        or_res[j] = or_res[j] | (term_hit[t] & or_cfg[t][j]);
      end
    end
  end

endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 5,
  localparam int CFG_W = 2 * N_IN + N_OUT,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase1_en,
  input  logic             phase2_en,
  input  logic [N_IN-1:0]  in_vec,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [N_OUT-1:0] out_vec
);

  logic [N_IN-1:0]                 in_q;
  logic [N_TERM-1:0][CFG_W-1:0]    stage_rows;
  logic [N_TERM-1:0][2*N_IN-1:0]   and_cfg;
  logic [N_TERM-1:0][N_OUT-1:0]    or_cfg;
  logic [N_TERM-1:0]               term_hit;
  logic [N_OUT-1:0]                or_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
    end else if (phase1_en) begin
      in_q <= in_vec;
    end
  end

  pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_row     (cfg_row),
    .cfg_data    (cfg_data),
    .load_active (phase1_en),
    .stage_rows  (stage_rows),
    .and_cfg     (and_cfg),
    .or_cfg      (or_cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_q     (in_q),
    .and_cfg  (and_cfg),
    .term_hit (term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_hit (term_hit),
    .or_cfg   (or_cfg),
    .or_res   (or_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vec <= '0;
    end else if (phase2_en) begin
      out_vec <= or_res;
    end
  end

endmodule

// File: rtl/pla_eval_chk.sv
module pla_eval_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 5,
  localparam int CFG_W = 2 * N_IN + N_OUT,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         phase1_en,
  input logic                         phase2_en,
  input logic [N_IN-1:0]              in_vec,
  input logic                         cfg_we,
  input logic [ROW_W-1:0]             cfg_row,
  input logic [N_OUT-1:0]             out_vec,
  input logic [N_IN-1:0]              in_q,
  input logic [N_OUT-1:0]             or_res,
  input logic [N_TERM-1:0][CFG_W-1:0] stage_rows
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_vec == '0 && in_q == '0 && stage_rows == '0));

  p_phase_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(phase1_en && phase2_en));

  p_in_capture_r6: assert property (@(posedge clk) disable iff (rst)
    phase1_en |=> (in_q == $past(in_vec)));

  p_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !phase1_en |=> $stable(in_q));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !phase2_en |=> $stable(out_vec));

  p_out_capture_r7: assert property (@(posedge clk) disable iff (rst)
    phase2_en |=> (out_vec == $past(or_res)));

  p_row_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (int'(cfg_row) >= N_TERM)) |=> $stable(stage_rows));

endmodule

bind pla_eval pla_eval_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase1_en  (phase1_en),
  .phase2_en  (phase2_en),
  .in_vec     (in_vec),
  .cfg_we     (cfg_we),
  .cfg_row    (cfg_row),
  .out_vec    (out_vec),
  .in_q       (in_q),
  .or_res     (or_res),
  .stage_rows (stage_rows)
);

// File: tb/pla_eval_test.sv
`timescale 1ns/1ps
module pla_eval_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phase1_en = 1'b0;
  logic       phase2_en = 1'b0;
  logic [2:0] in_vec = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_row = '0;
  logic [10:0] cfg_data = '0;
  logic [4:0] out_vec;

  int checks = 0;
  int errors = 0;

  // bench-side view of the matrix
  logic [5:0] ms_in [6];
  logic [4:0] ms_out[6];
  logic [5:0] ma_in [6];
  logic [4:0] ma_out[6];

  always #2 clk = ~clk;

  pla_eval uut (
    .clk(clk), .rst(rst), .phase1_en(phase1_en), .phase2_en(phase2_en),
    .in_vec(in_vec), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
    .out_vec(out_vec)
  );

  function automatic logic [4:0] model(input logic [2:0] x);
    logic [4:0] r = '0;
    for (int t = 0; t < 6; t++) begin
      logic alive = 1'b1;
      for (int i = 0; i < 3; i++) begin
        logic [1:0] c = ma_in[t][2*i +: 2];
        if (c == 2'b11) alive = 1'b0;
        else if (c == 2'b10 && !x[i]) alive = 1'b0;
        else if (c == 2'b01 && x[i]) alive = 1'b0;
      end
      if (alive) r = r | ma_out[t];
    end
    return r;
  endfunction

  function automatic logic [4:0] ref_eq(input logic [2:0] x);
    logic a = x[2], b = x[1], c = x[0];
    logic [4:0] r;
    r[0] = a | (!b & !c);
    r[1] = (a & !c) | (!a & b);
    r[2] = (!b & !c) | (!a & b);
    r[3] = (!b & c) | a;
    r[4] = a | b;
    return r;
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    checks++;
    if (out_vec !== exp) begin
      errors++;
      $display("FAIL %s: out_vec=%b expected=%b", tag, out_vec, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 6; t++) begin
      ms_in[t] = '0; ms_out[t] = '0; ma_in[t] = '0; ma_out[t] = '0;
    end
  endtask

  task automatic wr(input int row, input logic [5:0] ins, input logic [4:0] outs,
                    input bit with_cap, input logic [2:0] x);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_row = 3'(row);
    cfg_data = {outs, ins};
    if (with_cap) begin
      phase1_en = 1'b1;
      in_vec = x;
      for (int t = 0; t < 6; t++) begin
        ma_in[t] = ms_in[t]; ma_out[t] = ms_out[t];
      end
    end
    if (row < 6) begin
      ms_in[row] = ins; ms_out[row] = outs;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    phase1_en = 1'b0;
  endtask

  task automatic cap1(input logic [2:0] x);
    @(negedge clk);
    in_vec = x;
    phase1_en = 1'b1;
    for (int t = 0; t < 6; t++) begin
      ma_in[t] = ms_in[t]; ma_out[t] = ms_out[t];
    end
    @(negedge clk);
    phase1_en = 1'b0;
    in_vec = ~x;
  endtask

  task automatic cap2();
    @(negedge clk);
    phase2_en = 1'b1;
    @(negedge clk);
    phase2_en = 1'b0;
  endtask

  task automatic eval(input logic [2:0] x);
    cap1(x);
    cap2();
  endtask

  task automatic program_example();
    wr(0, 6'b10_00_00, 5'b11001, 0, 0); // a     -> f0 f3 f4
    wr(1, 6'b00_01_01, 5'b00101, 0, 0); // b'c'  -> f0 f2
    wr(2, 6'b10_00_01, 5'b00010, 0, 0); // ac'   -> f1
    wr(3, 6'b01_10_00, 5'b00110, 0, 0); // a'b   -> f1 f2
    wr(4, 6'b00_01_10, 5'b01000, 0, 0); // b'c   -> f3
    wr(5, 6'b00_10_00, 5'b10000, 0, 0); // b     -> f4
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset output", 5'b0);
    for (int x = 0; x < 8; x++) begin
      eval(3'(x));
      check("R1 cleared matrix", 5'b0);
    end
  endtask

  task automatic t_example();
    do_reset();
    program_example();
    for (int x = 0; x < 8; x++) begin
      eval(3'(x));
      check("R10 example equations", ref_eq(3'(x)));
      check("R3 shared-term model", model(3'(x)));
    end
  endtask

  task automatic t_hold();
    logic [4:0] prev;
    eval(3'b000);
    prev = out_vec;
    // new input captured but no output strobe
    cap1(3'b110);
    check("R6 out holds without phase2", prev);
    // in_vec moves but no input strobe; output strobe must use 110
    @(negedge clk);
    in_vec = 3'b001;
    @(negedge clk);
    phase2_en = 1'b1;
    #1;
    check("R7 not updated before edge", prev);
    @(negedge clk);
    phase2_en = 1'b0;
    check("R7 updated after phase2 edge", ref_eq(3'b110));
    check("R6 input held without phase1", model(3'b110));
  endtask

  task automatic t_reserved();
    do_reset();
    wr(0, 6'b00_00_11, 5'b00001, 0, 0); // reserved code on c -> f0
    wr(1, 6'b10_00_00, 5'b00010, 0, 0); // a -> f1
    wr(2, 6'b00_01_00, 5'b00100, 0, 0); // b' -> f2
    for (int x = 0; x < 8; x++) begin
      logic [2:0] v = 3'(x);
      eval(v);
      check("R2 literal codes", {2'b00, !v[1], v[2], 1'b0});
    end
  endtask

  task automatic t_const();
    do_reset();
    wr(3, 6'b00_00_00, 5'b01000, 0, 0); // all don't-care -> f3
    for (int x = 0; x < 8; x++) begin
      eval(3'(x));
      check("R4 R5 constant term and empty outputs", 5'b01000);
    end
  endtask

  task automatic t_timing();
    do_reset();
    wr(0, 6'b00_00_00, 5'b00001, 0, 0);
    cap2();
    check("R8 write not active before capture", 5'b0);
    eval(3'b101);
    check("R8 write active after capture", 5'b00001);
    wr(0, 6'b00_00_00, 5'b00010, 1, 3'b011); // write in the capture cycle
    cap2();
    check("R8 same-cycle write waits", 5'b00001);
    eval(3'b011);
    check("R8 write active after next capture", 5'b00010);
  endtask

  task automatic t_row_ignore();
    do_reset();
    program_example();
    wr(6, 6'b00_00_00, 5'b11111, 0, 0);
    wr(7, 6'b00_00_00, 5'b11111, 0, 0);
    eval(3'b000);
    check("R9 out-of-range rows ignored", ref_eq(3'b000));
    eval(3'b001);
    check("R9 out-of-range rows ignored", ref_eq(3'b001));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_example();
    t_hold();
    t_reserved();
    t_const();
    t_timing();
    t_row_ignore();
    do_reset();
    check("R1 reset after use", 5'b0);
    eval(3'b111);
    check("R1 matrix cleared after use", 5'b0);
    finish_run();
  end

endmodule